// File: doc/BRIEF.md
# Open-Drain Clock/Data Pin Control Register

This block is a single 32-bit control word for one pair of open-drain pins, a clock line and a data line, that software toggles to run a two-wire serial bus by hand. Each pin has a direction field and an output-value field. A write changes a field only when the matching mask bit in the same write data is set. Software can therefore move one line without first reading back the other.

A line goes high when software turns it into an input, and the external pull-up then lifts it. A line goes low when software makes it an output with a stored value of zero. The word also reports the level seen on each pin, after a synchronizer, and holds one pull-up-disable bit per pin. The pull-up-disable bits are routed out to the pad cells.

Bit layout, with pin p = 0 for clock and p = 1 for data, and base b = 8*p: direction at b+0 (1 = drive), direction mask at b+1, value at b+2, value mask at b+3, sampled input at b+4 (read-only), pull-up disable at b+5. All other bits read 0.

Top module: `odpad_reg`

## Requirements
- R1: On a write, the direction bit of pin p (bit 8p+0) loads from the write data only when the direction-mask bit 8p+1 is 1. Otherwise it keeps its value.
- R2: On a write, the value bit of pin p (bit 8p+2) loads from the write data only when the value-mask bit 8p+3 is 1. Otherwise it keeps its value.
- R3: A write whose mask bits select only one pin leaves the direction and value of the other pin unchanged.
- R4: A pin's output enable equals its direction bit. Its output data equals the stored value while enabled and is 0 while disabled.
- R5: Writing direction 0 with the direction mask set releases the pin (output enable 0). The pin then reads high through the pull-up unless an external device holds it low.
- R6: Writing direction 1, value 0 and both mask bits for a pin in one write drives that pin low (output enable 1, output data 0).
- R7: Bit 8p+4 reads the level of pin p as seen through a two-flop synchronizer. A change at the pin first shows on a read after the second rising clock edge. Write data to this bit is ignored.
- R8: The pull-up-disable bit of pin p (bit 8p+5) loads on every write, whatever the mask bits are. Its value is driven to the matching output and read back, and changes of direction or value do not disturb it.
- R9: During and after reset both pins are inputs, both stored values are 0, both pull-up-disable bits are 0, and both sampled-input bits read 1.
- R10: The mask bits and every bit outside the listed fields always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data with field and mask bits |
| rdData | output | 32 | Current control word and sampled levels |
| sclPadIn | input | 1 | Level seen at the clock pin |
| sdaPadIn | input | 1 | Level seen at the data pin |
| sclOe | output | 1 | Clock pin output enable |
| sclOut | output | 1 | Clock pin output data |
| sdaOe | output | 1 | Data pin output enable |
| sdaOut | output | 1 | Data pin output data |
| sclPullupDis | output | 1 | Clock pin pull-up disable |
| sdaPullupDis | output | 1 | Data pin pull-up disable |

## Verification
The hardest case to reach is a read where a pin's level is set by something other than the block itself. This happens when an external device holds a released line low, as a slow device stretching the clock would. The bench models each pin as a pull-up, ANDed with the block's drive and with an external pull-down that the bench controls. Random writes therefore meet random external pull-downs. Directed steps then count the exact edge at which a level change reaches the read data.

// File: rtl/odpad_pkg.sv
package odpad_pkg;

  localparam int NPINS      = 2;
  localparam int PIN_STRIDE = 8;

  // field offsets inside one pin's byte
  localparam int OFS_DIR  = 0;
  localparam int OFS_DIRM = 1;
  localparam int OFS_VAL  = 2;
  localparam int OFS_VALM = 3;
  localparam int OFS_IN   = 4;
  localparam int OFS_PUD  = 5;

  // strobes from write decode to datapath
  typedef struct packed {
    logic [NPINS-1:0] dirLd;
    logic [NPINS-1:0] dirD;
    logic [NPINS-1:0] valLd;
    logic [NPINS-1:0] valD;
    logic             pudLd;
    logic [NPINS-1:0] pudD;
  } wrStrobe_t;

  function automatic int fieldBit(input int pin, input int ofs);
    return pin * PIN_STRIDE + ofs;
  endfunction

endpackage

// File: rtl/odpad_sync.sv
module odpad_sync #(
  parameter int  STAGES   = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) shiftQ <= {STAGES{RST_VAL}};
    else       shiftQ <= {shiftQ[STAGES-2:0], din};
  end

  assign dout = shiftQ[STAGES-1];

  // R7: first stage captures the pin level of the previous edge
  assert_sync_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> shiftQ[0] == $past(din));

endmodule

// File: rtl/odpad_ctrl.sv
module odpad_ctrl
  import odpad_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output wrStrobe_t         st
);

  always_comb begin
    st = '0;
    st.pudLd = wrEn;
    for (int p = 0; p < NPINS; p++) begin
      st.dirLd[p] = wrEn & wrData[fieldBit(p, OFS_DIRM)];
      st.dirD[p]  = wrData[fieldBit(p, OFS_DIR)];
      st.valLd[p] = wrEn & wrData[fieldBit(p, OFS_VALM)];
      st.valD[p]  = wrData[fieldBit(p, OFS_VAL)];
      st.pudD[p]  = wrData[fieldBit(p, OFS_PUD)];
    end
  end

  // R1/R2: no field load without a write
  assert_no_load_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ($countones({st.dirLd, st.valLd, st.pudLd}) == 0));

endmodule

// File: rtl/odpad_dp.sv
module odpad_dp
  import odpad_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         st,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  pudOut,
  output logic [DATA_W-1:0] rdData
);

  logic [NPINS-1:0] dirQ;
  logic [NPINS-1:0] valQ;
  logic [NPINS-1:0] pudQ;
  logic [NPINS-1:0] inSync;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirQ[p] <= 1'b0;
        valQ[p] <= 1'b0;
      end else begin
        if (st.dirLd[p]) dirQ[p] <= st.dirD[p];
        if (st.valLd[p]) valQ[p] <= st.valD[p];
      end
    end

    odpad_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (padIn[p]),
      .dout (inSync[p])
    );

    assign padOe[p]  = dirQ[p];
    assign padOut[p] = dirQ[p] & valQ[p];

    assert_dir_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
      !st.dirLd[p] |=> $stable(dirQ[p]));
    assert_dir_load_R1: assert property (@(posedge clk) disable iff (!rstN)
      st.dirLd[p] |=> dirQ[p] == $past(st.dirD[p]));
    assert_val_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      !st.valLd[p] |=> $stable(valQ[p]));
    assert_drive_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
      padOut[p] |-> padOe[p]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pudQ <= '0;
    else if (st.pudLd)  pudQ <= st.pudD;
  end

  assign pudOut = pudQ;

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NPINS; p++) begin
      rdData[fieldBit(p, OFS_DIR)] = dirQ[p];
      rdData[fieldBit(p, OFS_VAL)] = valQ[p];
      rdData[fieldBit(p, OFS_IN)]  = inSync[p];
      rdData[fieldBit(p, OFS_PUD)] = pudQ[p];
    end
  end

  assert_pud_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.pudLd |=> pudQ == $past(st.pudD));

endmodule

// File: rtl/odpad_reg.sv
module odpad_reg
  import odpad_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sclPadIn,
  input  logic              sdaPadIn,
  output logic              sclOe,
  output logic              sclOut,
  output logic              sdaOe,
  output logic              sdaOut,
  output logic              sclPullupDis,
  output logic              sdaPullupDis
);

  wrStrobe_t        st;
  logic [NPINS-1:0] padOe;
  logic [NPINS-1:0] padOut;
  logic [NPINS-1:0] pudOut;

  odpad_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .st     (st)
  );

  odpad_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .padIn  ({sdaPadIn, sclPadIn}),
    .padOe  (padOe),
    .padOut (padOut),
    .pudOut (pudOut),
    .rdData (rdData)
  );

  assign sclOe        = padOe[0];
  assign sclOut       = padOut[0];
  assign sdaOe        = padOe[1];
  assign sdaOut       = padOut[1];
  assign sclPullupDis = pudOut[0];
  assign sdaPullupDis = pudOut[1];

  // R6: a driven-low request shows at the pins on the next edge
  assert_drive_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[0] && wrData[1] && !wrData[2] && wrData[3]) |=> (sclOe && !sclOut));

endmodule

// File: tb/sim_odpad_reg.sv
module sim_odpad_reg;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sclPadIn, sdaPadIn;
  logic        sclOe, sclOut, sdaOe, sdaOut, sclPullupDis, sdaPullupDis;
  logic        extSclLow = 1'b0, extSdaLow = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] mDir = '0, mVal = '0, mPud = '0;

  always #10 clk = ~clk;

  assign sclPadIn = (sclOe ? sclOut : 1'b1) & ~extSclLow;
  assign sdaPadIn = (sdaOe ? sdaOut : 1'b1) & ~extSdaLow;

  odpad_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sclPadIn(sclPadIn), .sdaPadIn(sdaPadIn),
    .sclOe(sclOe), .sclOut(sclOut), .sdaOe(sdaOe), .sdaOut(sdaOut),
    .sclPullupDis(sclPullupDis), .sdaPullupDis(sdaPullupDis)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic lvl(input int p);
    logic ext;
    ext = (p == 0) ? extSclLow : extSdaLow;
    return (mDir[p] ? mVal[p] : 1'b1) & ~ext;
  endfunction

  function automatic logic [31:0] expRead();
    logic [31:0] r = '0;
    for (int p = 0; p < 2; p++) begin
      r[8*p+0] = mDir[p];
      r[8*p+2] = mVal[p];
      r[8*p+4] = lvl(p);
      r[8*p+5] = mPud[p];
    end
    return r;
  endfunction

  function automatic void modelWrite(input logic [31:0] d);
    for (int p = 0; p < 2; p++) begin
      if (d[8*p+1]) mDir[p] = d[8*p+0];
      if (d[8*p+3]) mVal[p] = d[8*p+2];
      mPud[p] = d[8*p+5];
    end
  endfunction

  // drive at negedge, capture at posedge, check pins at the following negedge
  task automatic doWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(posedge clk);
    modelWrite(d);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic checkPins(input string req);
    check({req, " oe"},  {30'd0, sdaOe, sclOe}, {30'd0, mDir});
    check({req, " out"}, {30'd0, sdaOut, sclOut}, {30'd0, mDir & mVal});
    check({req, " pud"}, {30'd0, sdaPullupDis, sclPullupDis}, {30'd0, mPud});
  endtask

  task automatic settleRead(input string req);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(req, rdData, expRead());
  endtask

  initial begin
    void'($urandom(32'h5eed_0d0d));
    repeat (3) @(negedge clk);
    // R9 reset state, R10 zero bits
    check("R9 reset read", rdData, 32'h0000_1010);
    checkPins("R9");
    rstN = 1'b1;
    @(negedge clk);

    // R6 drive clock low only; R3 data untouched
    doWrite(32'h0000_000B);
    checkPins("R6");
    settleRead("R6/R3 clock low");

    // R6 data low with no clock masks; R3 clock untouched
    doWrite(32'h0000_0B00);
    checkPins("R3");
    settleRead("R3 data low");

    // R5 release clock
    doWrite(32'h0000_0002);
    checkPins("R5");
    settleRead("R5 clock released");

    // R5 released clock held low externally
    extSclLow = 1'b1;
    settleRead("R5 external hold");
    extSclLow = 1'b0;
    settleRead("R5 external free");

    // R1/R2 no mask bits: only pull-ups change (R8)
    doWrite(32'h0000_2525);
    checkPins("R1/R2 no mask");
    settleRead("R8 pud with no mask");

    // R8 pud kept across a write carrying it, direction change
    doWrite(32'h0000_2023);
    checkPins("R8 keep");

    // R7 write to input bits ignored, R10 mask bits read 0
    doWrite(32'hFFFF_E0F0 & ~32'h0000_0F0F | 32'h0000_2020);
    settleRead("R7/R10 ignored bits");

    // R7 synchronizer latency: release data then pull it low externally
    doWrite(32'h0000_0200);
    settleRead("R7 pre");
    extSdaLow = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R7 after one edge", {31'd0, rdData[12]}, 32'd1);
    @(posedge clk); @(negedge clk);
    check("R7 after two edges", {31'd0, rdData[12]}, 32'd0);
    extSdaLow = 1'b0;
    settleRead("R7 post");

    // R4 push-high value while enabled
    doWrite(32'h0000_000F);
    checkPins("R4 drive value");

    // random mix, R1 R2 R3 R4 R8
    for (int i = 0; i < 300; i++) begin
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d &= ~32'h0000_0A0A;
      extSclLow = ($urandom_range(0, 5) == 0);
      extSdaLow = ($urandom_range(0, 5) == 0);
      doWrite(d);
      checkPins("R1/R2/R4 random");
      settleRead("R1/R2/R8 random read");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule